// File: doc/BRIEF.md
# Echo-Suppressing Half-Duplex Bus Bridge

This block joins a local full-duplex serial port, which has one transmit line and one receive line, to a single shared half-duplex bus with two levels. The bus is recessive (logic 1) when nobody drives it and dominant (logic 0) when any node drives it. The bridge has no notion of baud rate, framing or character length. It passes each level through as it arrives. While the local transmit line is at space (0), the bridge turns on its bus driver. It turns the driver off as soon as the line returns to mark (1).

Because the bus is shared, every bit the local port sends comes straight back on the bus. The bridge therefore forces the local receive line to mark while the port is sending. It keeps that mask for a programmable number of clock cycles after the port returns to mark, so the delayed tail of its own bit cannot leak back as a glitch. Levels driven by other nodes reach the local receive line whenever no mask is in force.

If the bus reads dominant during the part of the hold window where the bridge's own echo has already cleared, some other node must be talking over the tail of the local transmission. The bridge flags this as a collision.

Top module: `hdb_bridge`

## Requirements
- R1: After reset, and while both the local transmit line and the bus stay at 1, `port_rxd_o`=1, `bus_drive_o`=0 and `collision_o`=0.
- R2: `bus_drive_o` is the inverse of `port_txd_i` delayed by exactly 3 clock edges (two synchroniser stages plus the output register), where 1 means the driver pulls the bus dominant.
- R3: While the synchronised local transmit level is 0, `port_rxd_o` is 1 on the following cycle, whatever the bus carries.
- R4: With local transmit idle and no hold active, a 0 on `bus_level_i` appears as 0 on `port_rxd_o` 3 edges later, and a 1 appears as 1.
- R5: After the synchronised transmit level returns to 1, `port_rxd_o` stays forced to 1 for HOLD_CYC further edges, counted from the first edge that sees the mark level.
- R6: `collision_o` is 1 on the cycle after an edge at which the synchronised transmit level is 1, the mark run counted as in R5 is at least 3 and less than HOLD_CYC, and the synchronised bus level is 0. Otherwise it is 0.
- R7: Once the hold has expired, `port_rxd_o` follows an arbitrary bus bit pattern bit by bit with the R4 latency, which makes the bridge independent of character format.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| port_txd_i | input | 1 | Local transmit line, asynchronous, 1 = mark |
| bus_level_i | input | 1 | Level read back from the shared bus, asynchronous, 0 = dominant |
| bus_drive_o | output | 1 | 1 = drive the bus dominant |
| port_rxd_o | output | 1 | Local receive line, 1 = mark |
| collision_o | output | 1 | Remote dominant level seen during the hold window |

## Verification
The echo mask and the collision flag can act in the same cycle. A remote node drives the bus dominant just after the local port has released it, while the hold window is still open. The receive line must then stay at mark even though the bus is at 0, and the collision flag must rise. The bench provokes this with directed remote pulses placed at every offset across the hold window and with long pseudo-random traffic on both sides. A behavioural model compares all three outputs on every clock, keeping track of the mark run length and the sample delays.

// File: rtl/hdb_pkg.sv
package hdb_pkg;
    localparam logic LVL_MARK     = 1'b1;
    localparam logic LVL_DOMINANT = 1'b0;

    typedef struct packed {
        logic txd;
        logic bus;
    } hdb_lines_t;

    typedef struct packed {
        logic drive;
        logic rxd;
        logic collide;
    } hdb_outs_t;

    function automatic int unsigned hdb_cnt_w(input int unsigned maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction
endpackage

// File: rtl/hdb_sync.sv
module hdb_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  hdb_pkg::hdb_lines_t raw_i,
    output hdb_pkg::hdb_lines_t sync_o
);
    hdb_pkg::hdb_lines_t chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                chain[s] <= '{txd: hdb_pkg::LVL_MARK, bus: hdb_pkg::LVL_MARK};
            end else if (s == 0) begin
                chain[s] <= raw_i;
            end else begin
                chain[s] <= chain[(s == 0) ? 0 : s - 1];
            end
        end
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/hdb_echo_guard.sv
module hdb_echo_guard #(
    parameter int unsigned HOLD_CYC = 8,
    parameter int unsigned LOOP_LAT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic txd_s,
    input  logic bus_s,
    output logic mask_o,
    output logic collide_o
);
    localparam int unsigned CW = hdb_pkg::hdb_cnt_w(HOLD_CYC);
    localparam logic [CW-1:0] RUN_SAT = CW'(HOLD_CYC);
    localparam logic [CW-1:0] RUN_CLEAN = CW'(LOOP_LAT);

    logic [CW-1:0] mark_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            mark_run <= RUN_SAT;
        end else if (txd_s != hdb_pkg::LVL_MARK) begin
            mark_run <= '0;
        end else if (mark_run != RUN_SAT) begin
            mark_run <= mark_run + 1'b1;
        end
    end

    always_comb begin
        mask_o    = (txd_s != hdb_pkg::LVL_MARK) || (mark_run < RUN_SAT);
        collide_o = (txd_s == hdb_pkg::LVL_MARK) && (mark_run >= RUN_CLEAN)
                 && (mark_run < RUN_SAT) && (bus_s == hdb_pkg::LVL_DOMINANT);
    end

    // R5: the first mark cycle after a space is still masked
    a_r5_hold_starts: assert property (@(posedge clk) disable iff (rst)
        $rose(txd_s) |-> mask_o);

    // R6: a collision is only reported inside the mask window
    a_r6_collide_in_mask: assert property (@(posedge clk) disable iff (rst)
        collide_o |-> mask_o);

    // R5: the run counter never leaves its saturated range
    a_r5_run_bound: assert property (@(posedge clk) disable iff (rst)
        mark_run <= RUN_SAT);
endmodule

// File: rtl/hdb_bridge.sv
module hdb_bridge #(
    parameter int unsigned HOLD_CYC    = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic port_txd_i,
    input  logic bus_level_i,
    output logic bus_drive_o,
    output logic port_rxd_o,
    output logic collision_o
);
    import hdb_pkg::*;

    localparam int unsigned LOOP_LAT = SYNC_STAGES + 1;

    hdb_lines_t raw, synced;
    hdb_outs_t  nxt, outs_q;
    logic       mask, collide;

    assign raw = '{txd: port_txd_i, bus: bus_level_i};

    hdb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw_i (raw),
        .sync_o(synced)
    );

    hdb_echo_guard #(.HOLD_CYC(HOLD_CYC), .LOOP_LAT(LOOP_LAT)) u_guard (
        .clk      (clk),
        .rst      (rst),
        .txd_s    (synced.txd),
        .bus_s    (synced.bus),
        .mask_o   (mask),
        .collide_o(collide)
    );

    always_comb begin
        nxt.drive   = (synced.txd == LVL_DOMINANT);
        nxt.rxd     = mask ? LVL_MARK : synced.bus;
        nxt.collide = collide;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            outs_q <= '{drive: 1'b0, rxd: LVL_MARK, collide: 1'b0};
        end else begin
            outs_q <= nxt;
        end
    end

    assign bus_drive_o = outs_q.drive;
    assign port_rxd_o  = outs_q.rxd;
    assign collision_o = outs_q.collide;

    // R2: driver reflects the previous synchronised transmit level
    a_r2_drive_tracks: assert property (@(posedge clk) disable iff (rst)
        bus_drive_o == ($past(synced.txd) == LVL_DOMINANT));

    // R3: a dominant receive level never coincides with local sending
    a_r3_no_self_echo: assert property (@(posedge clk) disable iff (rst)
        (port_rxd_o == LVL_DOMINANT) |-> ($past(synced.txd) == LVL_MARK));

    // R4: a dominant receive level always came from the bus
    a_r4_rxd_from_bus: assert property (@(posedge clk) disable iff (rst)
        (port_rxd_o == LVL_DOMINANT) |-> ($past(synced.bus) == LVL_DOMINANT));

    // R6: collision and a dominant receive level are exclusive
    a_r6_collide_masked: assert property (@(posedge clk) disable iff (rst)
        collision_o |-> (port_rxd_o == LVL_MARK));
endmodule

// File: tb/hdb_bridge_tb_top.sv
module hdb_bridge_tb_top;
    localparam int HOLD = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic txd = 1'b1;
    logic remote_dom = 1'b0;
    logic bus_drive, rxd, coll;
    wire  bus_level = ~bus_drive & ~remote_dom;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // model state: samples seen at the last two edges and run of marks
    int t1 = 1, t2 = 1, b1 = 1, b2 = 1, run = HOLD;
    int e_drive = 0, e_rxd = 1, e_coll = 0;
    string rxd_req = "R1";
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    hdb_bridge #(.HOLD_CYC(HOLD), .SYNC_STAGES(2)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .port_txd_i (txd),
        .bus_level_i(bus_level),
        .bus_drive_o(bus_drive),
        .port_rxd_o (rxd),
        .collision_o(coll)
    );

    task automatic check(input string req, input logic act, input int exp, input string what);
        n_cmp++;
        if (act !== exp[0]) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0b expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // one cycle: compare outputs of the last edge, apply inputs, predict next edge
    task automatic step(input logic new_txd, input logic new_remote);
        @(negedge clk);
        check("R2", bus_drive, e_drive, "bus_drive_o");
        check(rxd_req, rxd, e_rxd, "port_rxd_o");
        check("R6", coll, e_coll, "collision_o");
        txd = new_txd;
        remote_dom = new_remote;
        #1;
        e_drive = (t2 == 0) ? 1 : 0;
        if (t2 == 0) begin
            e_rxd = 1; rxd_req = "R3";
        end else if (run < HOLD) begin
            e_rxd = 1; rxd_req = "R5";
        end else begin
            e_rxd = b2; rxd_req = "R4/R7";
        end
        e_coll = (t2 == 1 && run >= 3 && run < HOLD && b2 == 0) ? 1 : 0;
        run = (t2 == 1) ? ((run + 1 > HOLD) ? HOLD : run + 1) : 0;
        t2 = t1; t1 = txd;
        b2 = b1; b1 = bus_level;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset values before any traffic
        check("R1", rxd, 1, "rxd after reset");
        check("R1", bus_drive, 0, "drive after reset");
        check("R1", coll, 0, "collision after reset");
        #1;
        e_drive = 0; e_rxd = 1; e_coll = 0; rxd_req = "R1";
        t1 = 1; t2 = 1; b1 = bus_level; b2 = 1; run = HOLD;
        t1 = txd;
        // R1: idle
        for (int i = 0; i < 10; i++) step(1, 0);
        // R4/R7: remote traffic with local idle
        for (int i = 0; i < 40; i++) step(1, (i % 3) == 0);
        // R2/R3: local character, remote quiet
        for (int i = 0; i < 30; i++) step((i % 5) > 1, 0);
        for (int i = 0; i < 12; i++) step(1, 0);
        // R3: remote talks over a local space
        for (int i = 0; i < 6; i++) step(0, 1);
        for (int i = 0; i < 14; i++) step(1, 0);
        // R5/R6: remote pulse at each offset of the hold window
        for (int off = 0; off < HOLD + 4; off++) begin
            for (int i = 0; i < 4; i++) step(0, 0);
            for (int i = 0; i < off; i++) step(1, 0);
            for (int i = 0; i < 2; i++) step(1, 1);
            for (int i = 0; i < HOLD + 6; i++) step(1, 0);
        end
        // R7: pseudo-random traffic on both sides
        for (int i = 0; i < 1500; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[3] | lfsr[7], lfsr[1] & lfsr[5] & lfsr[9]);
        end
        for (int i = 0; i < 4; i++) step(1, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule